// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block runs an external eight-input, 8-bit analog-to-digital converter from the FPGA side. User logic hands it a 3-bit channel number with a one-cycle go strobe. The block puts the channel code on the converter's select lines and pulses the address-latch strobe. It then pulses the start strobe and waits in two phases on the converter's end-of-conversion flag: first for the flag to drop, then for it to return high. One converter clock later it raises output-enable. It captures the 8-bit result and presents it with the channel tag and a one-cycle valid pulse.

The converter clock is a free-running divided copy of the system clock, and the elaboration step rejects divider settings outside the converter's allowed rate. The strobe widths come from the system clock period so that each strobe lasts at least 100 ns. A parameter can merge the two strobes into one shared pulse, which is only allowed when the converter clock is below 500 kHz. With scan enabled, every completed conversion starts the next one on the following channel, and channel 7 wraps to 0. A conversion whose flag has not come back within a set number of converter clocks is abandoned, and the block reports a timeout.

Top module: `adcseq_top`

## Requirements
- R1: The select lines carry the requested channel as a 3-bit binary code whose MSB is bit 2 (code 0 picks input 0, code 7 picks input 7). The result is tagged with that same code.
- R2: The address-latch strobe is high for exactly STROBE_CYC = ceil(STROBE_MIN_NS / SYS_CLK_NS) system cycles, which is 13 by default. The select lines do not change while it is high or in the cycle it falls.
- R3: In split mode the start strobe is high for exactly STROBE_CYC cycles. It rises only after the address-latch strobe has fallen, and the two are never high together.
- R4: A result is captured only after the synchronized end-of-conversion flag has been seen low after the start strobe, and then high again.
- R5: Output-enable rises no sooner than 2*CONV_HALF_DIV system cycles (one converter clock period) after end-of-conversion rises. It stays high until the result is latched and is low again in the cycle that valid is high.
- R6: Valid is high for exactly one cycle per completed conversion. It carries the data the converter drove while output-enable was high.
- R7: If end-of-conversion has not returned high within TIMEOUT_TICKS converter clocks after the start strobe ends, timeout pulses for one cycle. No valid is produced, the block returns to idle, and a later request converts normally.
- R8: The converter clock has a period of exactly 2*CONV_HALF_DIV system cycles (126 by default).
- R9: With MERGE_STROBES set, the address-latch and start strobes are one shared pulse, both high in the same STROBE_CYC cycles.
- R10: A go strobe that arrives while busy is ignored. It yields no extra result and does not change the select lines.
- R11: With scan enabled, each completed conversion is followed by one on channel+1 modulo 8. When scan is low at completion, the block returns to idle.
- R12: After reset every strobe, output-enable, busy, valid and timeout are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_go_i | input | 1 | One-cycle request to convert req_chan_i |
| req_chan_i | input | 3 | Requested channel code |
| scan_en_i | input | 1 | Step to the next channel after each result |
| busy_o | output | 1 | A conversion sequence is in progress |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 8 | Captured conversion result |
| res_chan_o | output | 3 | Channel the result belongs to |
| timeout_o | output | 1 | One-cycle pulse when a conversion is abandoned |
| adc_sel_o | output | 3 | Channel select lines to the converter |
| adc_ale_o | output | 1 | Address-latch strobe |
| adc_start_o | output | 1 | Start-of-conversion strobe |
| adc_oe_o | output | 1 | Output-enable to the converter |
| adc_clk_o | output | 1 | Divided converter clock |
| adc_eoc_i | input | 1 | End-of-conversion flag, asynchronous |
| adc_data_i | input | 8 | Converter result bus |

## Verification
The properties assume that req_go_i is a single-cycle strobe. They also assume that end-of-conversion only moves in response to a start strobe and that the result bus is stable while output-enable is high. The converter model in the bench follows these rules. It latches the channel on the falling edge of the address-latch strobe and clears its result on the rising edge of start. It drops the flag two converter clocks after start falls and raises it 64 converter clocks later. Its result bus is driven only while output-enable is high. A hang switch holds the flag low until the timeout pulse appears, so the timeout path is exercised without breaking those rules for the normal runs.

// File: rtl/adcseq_pkg.sv
// Shared types and elaboration helpers for the ADC conversion sequencer.
// Assumes: integer arithmetic on parameters only; nothing here is clocked.
package adcseq_pkg;

    // Sequencer states, one per phase of the converter handshake.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SET_ADDR,
        ST_ALE_PULSE,
        ST_START_PULSE,
        ST_WAIT_EOC_LOW,
        ST_WAIT_EOC_HIGH,
        ST_OE_DELAY,
        ST_CAPTURE,
        ST_DONE
    } seq_state_e;

    // Converter clock in kHz for a given system period and half divider.
    function automatic int conv_khz(input int sys_ns, input int half_div);
        return 1000000 / (sys_ns * 2 * half_div);
    endfunction

    // Smallest whole number of system cycles covering a minimum width.
    function automatic int cycles_for_ns(input int min_ns, input int sys_ns);
        return (min_ns + sys_ns - 1) / sys_ns;
    endfunction

    // Larger of two integers.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adcseq_clkdiv.sv
// Free-running divider producing the converter clock from the system clock.
// The output toggles every HALF_DIV system cycles. tick_o pulses for one
// system cycle, aligned with each rising edge of the converter clock.
// Assumes HALF_DIV >= 1.
module adcseq_clkdiv #(
    parameter int HALF_DIV = 63
) (
    input  logic clk,
    input  logic rst_n,
    output logic cclk_o,
    output logic tick_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count half periods and toggle the converter clock at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cclk_o <= 1'b0;
            tick_o <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            cclk_o <= ~cclk_o;
            tick_o <= ~cclk_o;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/adcseq_sync.sv
// Multi-stage synchronizer for an asynchronous level input.
// Assumes the input is a slow level (many system cycles per change).
// RST_VAL is the level the chain holds in reset.
module adcseq_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/adcseq_fsm.sv
// Conversion sequencer: select setup, address latch, start, two-phase
// end-of-conversion wait, output-enable delay, capture and scan restart.
// Assumes eoc_s_i is already synchronized and tick_i marks converter
// clock rising edges. All converter-facing outputs are registered.
module adcseq_fsm
    import adcseq_pkg::*;
#(
    parameter int  CHAN_W        = 3,
    parameter int  DATA_W        = 8,
    parameter int  SETUP_CYC     = 2,
    parameter int  STROBE_CYC    = 13,
    parameter int  OE_WAIT_CYC   = 126,
    parameter int  SETTLE_CYC    = 2,
    parameter int  TIMEOUT_TICKS = 96,
    parameter bit  MERGE_STROBES = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic              scan_i,
    input  logic              eoc_s_i,
    input  logic              tick_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CHAN_W-1:0] sel_o,
    output logic              ale_o,
    output logic              start_o,
    output logic              oe_o,
    output logic              busy_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic [CHAN_W-1:0] res_chan_o,
    output logic              timeout_o
);
    localparam int TMR_MAX = max2(max2(SETUP_CYC, STROBE_CYC),
                                  max2(OE_WAIT_CYC, SETTLE_CYC));
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int TO_W    = $clog2(TIMEOUT_TICKS + 1);

    seq_state_e         st_q, st_n;
    logic [TMR_W-1:0]   tmr_q;
    logic [TO_W-1:0]    to_cnt_q;
    logic               tmr_done;
    logic               in_wait;
    logic               to_hit;
    logic               ale_n;
    logic               start_n;

    assign tmr_done = (tmr_q == '0);
    assign in_wait  = (st_q == ST_WAIT_EOC_LOW) || (st_q == ST_WAIT_EOC_HIGH);
    assign to_hit   = in_wait && (to_cnt_q >= TO_W'(TIMEOUT_TICKS));

    // Next-state decision for the handshake sequence.
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE:          if (go_i) st_n = ST_SET_ADDR;
            ST_SET_ADDR:      if (tmr_done) st_n = ST_ALE_PULSE;
            ST_ALE_PULSE:     if (tmr_done) st_n = MERGE_STROBES ? ST_WAIT_EOC_LOW
                                                                 : ST_START_PULSE;
            ST_START_PULSE:   if (tmr_done) st_n = ST_WAIT_EOC_LOW;
            ST_WAIT_EOC_LOW:  if (to_hit) st_n = ST_IDLE;
                              else if (!eoc_s_i) st_n = ST_WAIT_EOC_HIGH;
            ST_WAIT_EOC_HIGH: if (to_hit) st_n = ST_IDLE;
                              else if (eoc_s_i) st_n = ST_OE_DELAY;
            ST_OE_DELAY:      if (tmr_done) st_n = ST_CAPTURE;
            ST_CAPTURE:       if (tmr_done) st_n = ST_DONE;
            ST_DONE:          st_n = scan_i ? ST_SET_ADDR : ST_IDLE;
            default:          st_n = ST_IDLE;
        endcase
    end

    // Strobe shape: the parameter picks shared or separate pulses.
    assign ale_n = (st_n == ST_ALE_PULSE);
    generate
        if (MERGE_STROBES) begin : g_merged
            assign start_n = ale_n;
        end else begin : g_split
            assign start_n = (st_n == ST_START_PULSE);
        end
    endgenerate

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // Phase timer: loaded on each state change, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (st_n != st_q) begin
            unique case (st_n)
                ST_SET_ADDR:    tmr_q <= TMR_W'(SETUP_CYC - 1);
                ST_ALE_PULSE,
                ST_START_PULSE: tmr_q <= TMR_W'(STROBE_CYC - 1);
                ST_OE_DELAY:    tmr_q <= TMR_W'(OE_WAIT_CYC - 1);
                ST_CAPTURE:     tmr_q <= TMR_W'(SETTLE_CYC - 1);
                default:        tmr_q <= '0;
            endcase
        end else if (!tmr_done) begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

    // Timeout counter: converter clock edges spent waiting on the flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_wait) to_cnt_q <= '0;
        else if (tick_i && !to_hit) to_cnt_q <= to_cnt_q + 1'b1;
    end

    // Channel register: loaded on request, advanced by scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_o <= '0;
        end else if (st_q == ST_IDLE && go_i) begin
            sel_o <= chan_i;
        end else if (st_q == ST_DONE && scan_i) begin
            sel_o <= sel_o + 1'b1;
        end
    end

    // Result register: latched at the end of the output-enable window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data_o <= '0;
            res_chan_o <= '0;
        end else if (st_q == ST_CAPTURE && tmr_done) begin
            res_data_o <= data_i;
            res_chan_o <= sel_o;
        end
    end

    // Registered control outputs decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_o     <= 1'b0;
            start_o   <= 1'b0;
            oe_o      <= 1'b0;
            busy_o    <= 1'b0;
            valid_o   <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            ale_o     <= ale_n;
            start_o   <= start_n;
            oe_o      <= (st_n == ST_CAPTURE);
            busy_o    <= (st_n != ST_IDLE);
            valid_o   <= (st_n == ST_DONE);
            timeout_o <= to_hit;
        end
    end
endmodule

// File: rtl/adcseq_top.sv
// Top of the ADC conversion sequencer. Derives strobe widths and the
// converter clock period from the system clock period, and rejects
// settings outside the converter's clock range at elaboration.
// Assumes a single system clock domain; adc_eoc_i may be asynchronous.
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int SYS_CLK_NS    = 8,
    parameter int STROBE_MIN_NS = 100,
    parameter int CONV_HALF_DIV = 63,
    parameter bit MERGE_STROBES = 1'b0,
    parameter int SETUP_CYC     = 2,
    parameter int SETTLE_CYC    = 2,
    parameter int TIMEOUT_TICKS = 96,
    parameter int SYNC_STAGES   = 2,
    parameter int CHAN_W        = 3,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_go_i,
    input  logic [CHAN_W-1:0] req_chan_i,
    input  logic              scan_en_i,
    output logic              busy_o,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic [CHAN_W-1:0] res_chan_o,
    output logic              timeout_o,
    output logic [CHAN_W-1:0] adc_sel_o,
    output logic              adc_ale_o,
    output logic              adc_start_o,
    output logic              adc_oe_o,
    output logic              adc_clk_o,
    input  logic              adc_eoc_i,
    input  logic [DATA_W-1:0] adc_data_i
);
    localparam int STROBE_CYC  = cycles_for_ns(STROBE_MIN_NS, SYS_CLK_NS);
    localparam int CONV_PERIOD = 2 * CONV_HALF_DIV;
    localparam int CONV_KHZ    = conv_khz(SYS_CLK_NS, CONV_HALF_DIV);
    localparam bit RATE_OK     = (CONV_KHZ >= 10) && (CONV_KHZ <= 1200);
    localparam bit MERGE_OK    = !MERGE_STROBES || (CONV_KHZ < 500);

    // Elaboration guard on the divider and strobe-merge settings.
    generate
        if (!RATE_OK || !MERGE_OK) begin : g_cfg_bad
            $error("adcseq_top: converter clock setting out of range");
        end
    endgenerate

    logic cclk_tick;
    logic eoc_s;

    adcseq_clkdiv #(
        .HALF_DIV (CONV_HALF_DIV)
    ) u_clkdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .cclk_o (adc_clk_o),
        .tick_o (cclk_tick)
    );

    adcseq_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_eoc_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (adc_eoc_i),
        .sync_o  (eoc_s)
    );

    adcseq_fsm #(
        .CHAN_W        (CHAN_W),
        .DATA_W        (DATA_W),
        .SETUP_CYC     (SETUP_CYC),
        .STROBE_CYC    (STROBE_CYC),
        .OE_WAIT_CYC   (CONV_PERIOD),
        .SETTLE_CYC    (SETTLE_CYC),
        .TIMEOUT_TICKS (TIMEOUT_TICKS),
        .MERGE_STROBES (MERGE_STROBES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (req_go_i),
        .chan_i     (req_chan_i),
        .scan_i     (scan_en_i),
        .eoc_s_i    (eoc_s),
        .tick_i     (cclk_tick),
        .data_i     (adc_data_i),
        .sel_o      (adc_sel_o),
        .ale_o      (adc_ale_o),
        .start_o    (adc_start_o),
        .oe_o       (adc_oe_o),
        .busy_o     (busy_o),
        .valid_o    (res_valid_o),
        .res_data_o (res_data_o),
        .res_chan_o (res_chan_o),
        .timeout_o  (timeout_o)
    );
endmodule

// File: rtl/adcseq_chk.sv
// Property checker for adcseq_top, attached by bind below.
// Assumes a synchronous active-low reset and that the ports are observed
// at the system clock.
module adcseq_chk #(
    parameter int STROBE_CYC = 13,
    parameter bit MERGE      = 1'b0,
    parameter int CHAN_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              res_valid_o,
    input logic              timeout_o,
    input logic [CHAN_W-1:0] adc_sel_o,
    input logic              adc_ale_o,
    input logic              adc_start_o,
    input logic              adc_oe_o
);
    logic [15:0] ale_run_q;
    logic [15:0] start_run_q;

    // Run lengths of the two strobes, cleared while each is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_run_q   <= '0;
            start_run_q <= '0;
        end else begin
            ale_run_q   <= adc_ale_o   ? ale_run_q + 1'b1   : '0;
            start_run_q <= adc_start_o ? start_run_q + 1'b1 : '0;
        end
    end

    assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_ale_o |-> $stable(adc_sel_o));
    assert_sel_after_ale_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_ale_o) |-> $stable(adc_sel_o));
    assert_ale_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_ale_o) |-> (ale_run_q == 16'(STROBE_CYC)));
    assert_start_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_start_o) |-> (start_run_q == 16'(STROBE_CYC)));

    generate
        if (MERGE) begin : g_merged
            assert_shared_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
                adc_ale_o == adc_start_o);
        end else begin : g_split
            assert_split_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !(adc_ale_o && adc_start_o));
        end
    endgenerate

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);
    assert_oe_before_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> ($past(adc_oe_o) && !adc_oe_o));
    assert_timeout_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!res_valid_o && !busy_o));
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!adc_ale_o && !adc_start_o && !adc_oe_o));
endmodule

bind adcseq_top adcseq_chk #(
    .STROBE_CYC (STROBE_CYC),
    .MERGE      (MERGE_STROBES),
    .CHAN_W     (CHAN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .res_valid_o (res_valid_o),
    .timeout_o   (timeout_o),
    .adc_sel_o   (adc_sel_o),
    .adc_ale_o   (adc_ale_o),
    .adc_start_o (adc_start_o),
    .adc_oe_o    (adc_oe_o)
);

// File: tb/adcseq_model.sv
// Behavioural converter model for the bench: latches the channel when the
// address strobe falls, clears on start rise, drops the flag two converter
// clocks after start falls and raises it 64 converter clocks later.
module adcseq_model (
    input  logic        cclk,
    input  logic        ale,
    input  logic        start,
    input  logic        oe,
    input  logic [2:0]  sel,
    input  logic        hang,
    input  logic        release_i,
    input  logic [63:0] analog,
    output logic        eoc,
    output logic [7:0]  data
);
    logic [2:0] ch_q;
    logic [7:0] conv_q;

    initial begin
        eoc    = 1'b1;
        conv_q = 8'h00;
        ch_q   = 3'd0;
    end

    always @(negedge ale) ch_q = sel;

    always begin
        @(posedge start);
        conv_q = 8'h00;
        @(negedge start);
        repeat (2) @(posedge cclk);
        eoc = 1'b0;
        if (hang) begin
            @(posedge release_i);
        end else begin
            repeat (64) @(posedge cclk);
            conv_q = analog[ch_q*8 +: 8];
        end
        eoc = 1'b1;
    end

    assign data = oe ? conv_q : 8'h00;
endmodule

// File: tb/adcseq_top_tb.sv
module adcseq_top_tb;
    localparam int STROBE  = 13;
    localparam int PERIOD  = 126;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       go = 1'b0, scan = 1'b0, hang = 1'b0;
    logic [2:0] chan = 3'd0;
    logic       busy, valid, tout, ale, start, oe, cclk, eoc;
    logic [7:0] rdata, adata;
    logic [2:0] rchan, sel;
    logic [63:0] analog;

    logic       m_go = 1'b0;
    logic       m_busy, m_valid, m_tout, m_ale, m_start, m_oe, m_cclk, m_eoc;
    logic [7:0] m_rdata, m_adata;
    logic [2:0] m_rchan, m_sel;

    adcseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_go_i(go), .req_chan_i(chan),
        .scan_en_i(scan), .busy_o(busy), .res_valid_o(valid),
        .res_data_o(rdata), .res_chan_o(rchan), .timeout_o(tout),
        .adc_sel_o(sel), .adc_ale_o(ale), .adc_start_o(start),
        .adc_oe_o(oe), .adc_clk_o(cclk), .adc_eoc_i(eoc), .adc_data_i(adata));

    adcseq_model u_mdl (
        .cclk(cclk), .ale(ale), .start(start), .oe(oe), .sel(sel),
        .hang(hang), .release_i(tout), .analog(analog), .eoc(eoc), .data(adata));

    adcseq_top #(.CONV_HALF_DIV(130), .MERGE_STROBES(1'b1)) u_dut_mrg (
        .clk(clk), .rst_n(rst_n), .req_go_i(m_go), .req_chan_i(3'd4),
        .scan_en_i(1'b0), .busy_o(m_busy), .res_valid_o(m_valid),
        .res_data_o(m_rdata), .res_chan_o(m_rchan), .timeout_o(m_tout),
        .adc_sel_o(m_sel), .adc_ale_o(m_ale), .adc_start_o(m_start),
        .adc_oe_o(m_oe), .adc_clk_o(m_cclk), .adc_eoc_i(m_eoc), .adc_data_i(m_adata));

    adcseq_model u_mdl_m (
        .cclk(m_cclk), .ale(m_ale), .start(m_start), .oe(m_oe), .sel(m_sel),
        .hang(1'b0), .release_i(1'b0), .analog(analog), .eoc(m_eoc), .data(m_adata));

    int checks = 0, fails = 0;
    int valid_cnt = 0, tout_cnt = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] level_of(input int ch);
        return analog[ch*8 +: 8];
    endfunction

    // Scoreboard queue of expected {channel, data}.
    logic [10:0] exp_q[$];

    task automatic expect_item(input int ch);
        exp_q.push_back({3'(ch), level_of(ch)});
    endtask

    task automatic issue(input int ch);
        @(negedge clk);
        go = 1'b1; chan = 3'(ch);
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // Monitor: pop and compare each result; R4 flag tracking.
    bit eoc_fell = 1'b0;
    always @(negedge clk) begin
        if (start) eoc_fell = 1'b0;
        else if (!eoc) eoc_fell = 1'b1;
        if (rst_n && tout) tout_cnt++;
        if (rst_n && valid) begin
            valid_cnt++;
            chk(eoc_fell && eoc, "R4 flag low-then-high before result", int'(eoc_fell), 1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected result", int'(rchan), -1);
            end else begin
                logic [10:0] e;
                e = exp_q.pop_front();
                chk(rchan == e[10:8], "R1 result channel tag", int'(rchan), int'(e[10:8]));
                chk(rdata == e[7:0], "R6 result data", int'(rdata), int'(e[7:0]));
            end
        end
    end

    // Strobe width and ordering monitor (R2, R3).
    int ale_len = 0, st_len = 0;
    bit ale_seen = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ale) ale_len++;
            else if (ale_len != 0) begin
                chk(ale_len == STROBE, "R2 address strobe width", ale_len, STROBE);
                ale_len = 0;
                ale_seen = 1'b1;
            end
            if (start) begin
                if (st_len == 0) chk(ale_seen && !ale, "R3 start after address strobe", int'(ale), 0);
                st_len++;
            end else if (st_len != 0) begin
                chk(st_len == STROBE, "R3 start strobe width", st_len, STROBE);
                st_len = 0;
                ale_seen = 1'b0;
            end
        end
    end

    // Output-enable delay monitor (R5).
    bit eoc_prev = 1'b1, oe_prev = 1'b0, counting = 1'b0;
    int oe_gap = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (eoc && !eoc_prev) begin counting = 1'b1; oe_gap = 0; end
            else if (counting) oe_gap++;
            if (oe && !oe_prev && counting) begin
                chk(oe_gap >= PERIOD, "R5 output-enable delay", oe_gap, PERIOD);
                counting = 1'b0;
            end
        end
        eoc_prev = eoc;
        oe_prev  = oe;
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic merged_test();
        int mism = 0;
        int width = 0;
        int got = 0;
        @(negedge clk);
        m_go = 1'b1;
        @(negedge clk);
        m_go = 1'b0;
        while (!m_valid) begin
            @(negedge clk);
            if (m_ale != m_start) mism++;
            if (m_ale) width++;
        end
        got = 1;
        chk(mism == 0, "R9 shared strobe cycles differ", mism, 0);
        chk(width == STROBE, "R9 shared strobe width", width, STROBE);
        chk(m_rchan == 3'd4 && got == 1, "R9 merged result channel", int'(m_rchan), 4);
        chk(m_rdata == level_of(4), "R9 merged result data", int'(m_rdata), int'(level_of(4)));
    endtask

    task automatic main_test();
        int rises = 0, first = 0, second = 0;
        bit prev;
        int base;
        // R8: converter clock period.
        prev = cclk;
        for (int i = 0; i < 600 && rises < 2; i++) begin
            @(negedge clk);
            if (cclk && !prev) begin
                rises++;
                if (rises == 1) first = i; else second = i;
            end
            prev = cclk;
        end
        chk(second - first == PERIOD, "R8 converter clock period", second - first, PERIOD);

        // R1: channel 0, with an ignored request during the conversion (R10).
        expect_item(0);
        issue(0);
        chk(busy == 1'b1, "R1 busy after request", int'(busy), 1);
        repeat (200) @(negedge clk);
        chk(sel == 3'd0, "R1 select code 000 for input 0", int'(sel), 0);
        issue(5);
        repeat (5) @(negedge clk);
        chk(sel == 3'd0, "R10 select unchanged by request while busy", int'(sel), 0);
        wait_idle();
        repeat (50) @(negedge clk);
        chk(valid_cnt == 1, "R10 one result only", valid_cnt, 1);

        // R1: channel 7.
        expect_item(7);
        issue(7);
        repeat (200) @(negedge clk);
        chk(sel == 3'd7, "R1 select code 111 for input 7", int'(sel), 7);
        wait_idle();

        // R11: scan from 6, wrapping to 0, stopping when scan drops.
        base = valid_cnt;
        scan = 1'b1;
        expect_item(6); expect_item(7); expect_item(0);
        issue(6);
        while (valid_cnt < base + 2) @(negedge clk);
        scan = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        chk(valid_cnt == base + 3, "R11 scan result count", valid_cnt - base, 3);
        chk(sel == 3'd0, "R11 scan wrapped to channel 0", int'(sel), 0);

        // R7: timeout with the flag held low.
        base = valid_cnt;
        hang = 1'b1;
        issue(3);
        wait_idle();
        hang = 1'b0;
        repeat (20) @(negedge clk);
        chk(tout_cnt == 1, "R7 timeout pulse count", tout_cnt, 1);
        chk(valid_cnt == base, "R7 no result on timeout", valid_cnt - base, 0);
        chk(busy == 1'b0, "R7 idle after timeout", int'(busy), 0);

        // R7: recovery with a normal conversion on channel 2.
        expect_item(2);
        issue(2);
        wait_idle();
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all expected results seen", exp_q.size(), 0);
    endtask

    initial begin
        for (int c = 0; c < 8; c++) analog[c*8 +: 8] = 8'(8'h1B + c * 8'h1D);
        repeat (5) @(negedge clk);
        chk(!ale && !start && !oe, "R12 strobes low in reset", int'({ale, start, oe}), 0);
        chk(!busy && !valid && !tout, "R12 status low in reset", int'({busy, valid, tout}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !m_busy, "R12 idle after reset", int'(busy), 0);
        fork
            main_test();
            merged_test();
        join
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule